// File: doc/BRIEF.md
# Buffered Page Write Sequencer

This block turns a write request (a linear byte address, a byte count and a verify flag) into the command frames that program a serial flash through the flash's internal page buffer. It splits the range at page boundaries and handles one page per step. If a step covers only part of a page, the block first has the flash copy that page into its buffer, so the untouched bytes survive. Each page is then written with a buffered program frame that carries the payload bytes. When verify is on, a compare frame follows the program frame.

After every command frame the block polls the device status until the ready bit is set, and only then starts the next frame. Payload arrives on a valid/ready byte stream. Frames leave on a valid/ready byte stream toward an SPI master, with a last flag that marks where chip select may drop. The master returns the status byte on a separate strobe.

Top module: `page_write_seq`

## Requirements
- R1: The first chunk is `PAGE_BYTES - (addr % PAGE_BYTES)` bytes, or the total length if that is smaller. Every later chunk is a full page, or the remainder if less than a page is left.
- R2: A chunk shorter than `PAGE_BYTES` is preceded by a buffer-load frame followed by a status poll. The frame is four bytes: `0x53`, flash address bits 23:16, bits 15:8, then `0x00`. The flash address is the page number shifted left by `OFF_W`.
- R3: Each chunk is written by a program frame. It starts with `0x82` and three address bytes, most significant first, holding `(page << OFF_W) + offset`. The chunk's payload bytes follow in stream order. `tx_last` is set only on the final byte of a frame.
- R4: After every command frame the block sends the status poll frame (`0xD7`, then `0x00` with `tx_last`). It then waits for `rx_valid`. While bit 7 of `rx_data` is 0 it polls again, and no command frame starts before a reply with bit 7 set.
- R5: With verify set, every program frame is followed by a compare frame and a poll. The compare frame is `0x60`, address bits 23:16, bits 15:8, `0x00`. If bit 6 of the ready reply to that poll is 1, the write stops with `err` high and no further frame is sent. Bit 6 of every other reply is ignored.
- R6: After each chunk the page number increases by one and the in-page offset becomes zero.
- R7: `bytes_done` is cleared when a request is accepted. It grows by the chunk length after each chunk completes (after the chunk's compare, when verify is set). It keeps its value after an abort until the next request.
- R8: `pl_ready` is high only while the payload bytes of a program frame are being sent. It stays low during headers and polling.
- R9: A request of length zero completes with `done`, with `err` low, and with no frame sent.
- R10: `req_ready` is high only while the block is idle. `done` is a single-cycle pulse at the end of each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request strobe |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | ADDR_W | Linear start byte address |
| req_len | input | LEN_W | Number of bytes to write |
| req_verify | input | 1 | Compare each page after programming |
| pl_valid | input | 1 | Payload byte valid |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| tx_valid | output | 1 | Outgoing frame byte valid |
| tx_ready | input | 1 | SPI master takes the byte |
| tx_data | output | 8 | Outgoing frame byte |
| tx_last | output | 1 | Final byte of the frame |
| rx_valid | input | 1 | Status byte returned for a poll |
| rx_data | input | 8 | Status byte |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Last request aborted on compare mismatch |
| bytes_done | output | LEN_W | Bytes committed so far |

## Verification
The assertions check on every cycle that a chunk fits within its page and does not exceed the remaining count. They also check that a step clears the offset and advances the page, that `bytes_done` never drops within a request, and that header bytes hold still under back-pressure. The remaining per-cycle checks cover the payload count staying inside the chunk, a busy reply sending the block back to polling, and the error rising only with the `done` pulse. Only the bench scenarios can show that the complete frame stream is correct byte for byte, including the load-frame choice and the payload order. The same holds for the abort stopping on the right page, the mismatch bit being ignored outside compare polls, and the count surviving an abort.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam int FLASH_AW = 24;

  localparam logic [7:0] OP_BUF_LOAD = 8'h53;
  localparam logic [7:0] OP_PROGRAM  = 8'h82;
  localparam logic [7:0] OP_COMPARE  = 8'h60;
  localparam logic [7:0] OP_STATUS   = 8'hD7;

  localparam logic [7:0] ST_RDY_MASK = 8'h80;
  localparam logic [7:0] ST_MIS_MASK = 8'h40;

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_LOAD_HDR, S_PROG_HDR, S_PROG_DAT, S_CMP_HDR,
    S_POLL_CMD, S_POLL_PAD, S_POLL_WAIT, S_STEP, S_FIN
  } pws_state_e;

  typedef enum logic [1:0] {A_LOAD, A_PROG, A_CMP} pws_after_e;
endpackage

// File: rtl/pws_chunker.sv
module pws_chunker #(
  parameter int PAGE_BYTES = 264,
  parameter int OFF_W      = 9,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int FA_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              step,
  output logic [FA_W-1:0]   page_addr,
  output logic [FA_W-1:0]   byte_addr,
  output logic [LEN_W-1:0]  chunk,
  output logic              partial,
  output logic              last_chunk,
  output logic [LEN_W-1:0]  bytes_done
);
  localparam logic [ADDR_W-1:0] PG_A = ADDR_W'(PAGE_BYTES);
  localparam logic [LEN_W-1:0]  PG_L = LEN_W'(PAGE_BYTES);

  logic [ADDR_W-1:0] page_q, page_n;
  logic [OFF_W-1:0]  off_q, off_n, off_in;
  logic [LEN_W-1:0]  rem_q, rem_n, chunk_q, chunk_n, cnt_q, cnt_n;
  logic [LEN_W-1:0]  room, rem_after;

  always_comb begin
    page_n    = page_q;
    off_n     = off_q;
    rem_n     = rem_q;
    chunk_n   = chunk_q;
    cnt_n     = cnt_q;
    off_in    = OFF_W'(ld_addr % PG_A);
    room      = PG_L - LEN_W'(off_in);
    rem_after = rem_q - chunk_q;
    if (load) begin
      page_n  = ld_addr / PG_A;
      off_n   = off_in;
      rem_n   = ld_len;
      chunk_n = (ld_len < room) ? ld_len : room;
      cnt_n   = '0;
    end else if (step) begin
      page_n  = page_q + 1'b1;
      off_n   = '0;
      rem_n   = rem_after;
      chunk_n = (rem_after > PG_L) ? PG_L : rem_after;
      cnt_n   = cnt_q + chunk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      off_q   <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      cnt_q   <= '0;
    end else if (load || step) begin
      page_q  <= page_n;
      off_q   <= off_n;
      rem_q   <= rem_n;
      chunk_q <= chunk_n;
      cnt_q   <= cnt_n;
    end
  end

  assign page_addr  = FA_W'({page_q, {OFF_W{1'b0}}});
  assign byte_addr  = FA_W'({page_q, off_q});
  assign chunk      = chunk_q;
  assign partial    = (chunk_q != PG_L);
  assign last_chunk = (rem_q == chunk_q);
  assign bytes_done = cnt_q;

  // R1: a chunk never runs past the end of its page
  p_chunk_in_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(chunk_q) + 32'(off_q)) <= PAGE_BYTES);

  // R1: a chunk never exceeds what is left to write
  p_chunk_le_rem_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_q <= rem_q);

  // R6: stepping moves to the start of the following page
  p_step_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (off_q == '0) && (page_q == $past(page_q) + 1'b1));

  // R7: the committed count never falls within a request
  p_count_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int FA_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_verify,
  output logic             req_ready,
  output logic             ld,
  output logic             stp,
  input  logic [FA_W-1:0]  page_addr,
  input  logic [FA_W-1:0]  byte_addr,
  input  logic [LEN_W-1:0] chunk,
  input  logic             partial,
  input  logic             last_chunk,
  input  logic             pl_valid,
  input  logic [7:0]       pl_data,
  output logic             pl_ready,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             done,
  output logic             err
);
  pws_state_e       st, st_n;
  pws_after_e       aft, aft_n;
  logic [1:0]       hidx, hidx_n;
  logic [LEN_W-1:0] dcnt, dcnt_n;
  logic             ver_q, ver_n, err_q, err_n;
  logic             st_rdy, st_mis;

  assign st_rdy = |(rx_data & ST_RDY_MASK);
  assign st_mis = |(rx_data & ST_MIS_MASK);

  always_comb begin
    st_n      = st;
    aft_n     = aft;
    hidx_n    = hidx;
    dcnt_n    = dcnt;
    ver_n     = ver_q;
    err_n     = err_q;
    req_ready = 1'b0;
    ld        = 1'b0;
    stp       = 1'b0;
    tx_valid  = 1'b0;
    tx_data   = 8'h00;
    tx_last   = 1'b0;
    pl_ready  = 1'b0;
    case (st)
      S_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          ld    = 1'b1;
          err_n = 1'b0;
          ver_n = req_verify;
          st_n  = (req_len == '0) ? S_FIN : S_PLAN;
        end
      end
      S_PLAN: begin
        hidx_n = 2'd0;
        st_n   = partial ? S_LOAD_HDR : S_PROG_HDR;
      end
      S_LOAD_HDR, S_CMP_HDR: begin
        tx_valid = 1'b1;
        case (hidx)
          2'd0:    tx_data = (st == S_LOAD_HDR) ? OP_BUF_LOAD : OP_COMPARE;
          2'd1:    tx_data = page_addr[23:16];
          2'd2:    tx_data = page_addr[15:8];
          default: tx_data = 8'h00;
        endcase
        tx_last = (hidx == 2'd3);
        if (tx_ready) begin
          if (hidx == 2'd3) begin
            hidx_n = 2'd0;
            aft_n  = (st == S_LOAD_HDR) ? A_LOAD : A_CMP;
            st_n   = S_POLL_CMD;
          end else begin
            hidx_n = hidx + 2'd1;
          end
        end
      end
      S_PROG_HDR: begin
        tx_valid = 1'b1;
        case (hidx)
          2'd0:    tx_data = OP_PROGRAM;
          2'd1:    tx_data = byte_addr[23:16];
          2'd2:    tx_data = byte_addr[15:8];
          default: tx_data = byte_addr[7:0];
        endcase
        if (tx_ready) begin
          if (hidx == 2'd3) begin
            hidx_n = 2'd0;
            dcnt_n = '0;
            st_n   = S_PROG_DAT;
          end else begin
            hidx_n = hidx + 2'd1;
          end
        end
      end
      S_PROG_DAT: begin
        tx_valid = pl_valid;
        tx_data  = pl_data;
        pl_ready = tx_ready;
        tx_last  = (dcnt == chunk - LEN_W'(1));
        if (pl_valid && tx_ready) begin
          if (tx_last) begin
            aft_n = A_PROG;
            st_n  = S_POLL_CMD;
          end else begin
            dcnt_n = dcnt + LEN_W'(1);
          end
        end
      end
      S_POLL_CMD: begin
        tx_valid = 1'b1;
        tx_data  = OP_STATUS;
        if (tx_ready) st_n = S_POLL_PAD;
      end
      S_POLL_PAD: begin
        tx_valid = 1'b1;
        tx_last  = 1'b1;
        if (tx_ready) st_n = S_POLL_WAIT;
      end
      S_POLL_WAIT: begin
        hidx_n = 2'd0;
        if (rx_valid) begin
          if (!st_rdy) begin
            st_n = S_POLL_CMD;
          end else begin
            case (aft)
              A_LOAD:  st_n = S_PROG_HDR;
              A_PROG:  st_n = ver_q ? S_CMP_HDR : S_STEP;
              default: begin
                if (st_mis) begin
                  err_n = 1'b1;
                  st_n  = S_FIN;
                end else begin
                  st_n  = S_STEP;
                end
              end
            endcase
          end
        end
      end
      S_STEP: begin
        stp  = 1'b1;
        st_n = last_chunk ? S_FIN : S_PLAN;
      end
      S_FIN:   st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      aft   <= A_LOAD;
      hidx  <= 2'd0;
      dcnt  <= '0;
      ver_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st    <= st_n;
      aft   <= aft_n;
      hidx  <= hidx_n;
      dcnt  <= dcnt_n;
      ver_q <= ver_n;
      err_q <= err_n;
    end
  end

  assign done = (st == S_FIN);
  assign err  = err_q;

  // R3: header and poll bytes stay put while the master stalls
  p_hdr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && (st != S_PROG_DAT)) |=> (tx_valid && $stable(tx_data)));

  // R3: the payload counter stays inside the current chunk
  p_data_in_chunk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG_DAT) |-> (dcnt < chunk));

  // R4: a busy reply always leads to another poll
  p_busy_repoll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL_WAIT && rx_valid && !st_rdy) |=> (st == S_POLL_CMD));

  // R5: the error flag only rises together with the end pulse
  p_err_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> done);

  // R10: the end pulse lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pws_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int OFF_W      = 9,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_verify,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [7:0]        pl_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  bytes_done
);
  logic                ld, stp, partial, last_chunk;
  logic [FLASH_AW-1:0] page_addr, byte_addr;
  logic [LEN_W-1:0]    chunk;

  pws_chunker #(
    .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .FA_W(FLASH_AW)
  ) u_chunk (
    .clk(clk), .rst_n(rst_n), .load(ld), .ld_addr(req_addr), .ld_len(req_len),
    .step(stp), .page_addr(page_addr), .byte_addr(byte_addr), .chunk(chunk),
    .partial(partial), .last_chunk(last_chunk), .bytes_done(bytes_done)
  );

  pws_ctrl #(.LEN_W(LEN_W), .FA_W(FLASH_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .req_verify(req_verify), .req_ready(req_ready), .ld(ld), .stp(stp),
    .page_addr(page_addr), .byte_addr(byte_addr), .chunk(chunk),
    .partial(partial), .last_chunk(last_chunk), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_ready(pl_ready), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .done(done), .err(err)
  );
endmodule

// File: tb/page_write_seq_test.sv
module page_write_seq_test;
  localparam int PB = 264;
  localparam int OW = 9;
  localparam int AW = 24;
  localparam int LW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_verify;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len, bytes_done;
  logic          pl_valid, pl_ready, tx_valid, tx_ready, tx_last;
  logic [7:0]    pl_data, tx_data, rx_data;
  logic          rx_valid, done, err;

  page_write_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_verify(req_verify),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .done(done), .err(err),
    .bytes_done(bytes_done)
  );

  int n_cmp = 0, n_bad = 0;
  logic [8:0] log_q[$], exp_q[$], cur_q[$];
  int pidx = 0, tseed = 0, busy_left = 0, cmp_n = 0, mm = -1;
  int poll_bad = 0, cmd_early = 0, pl_bad = 0, rx_cnt = 0;
  bit dev_ready = 1'b1, last_cmp = 1'b0, exp_err = 1'b0, timed_out = 1'b0;
  int exp_bytes = 0;
  logic [7:0] rx_byte = 8'h00;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pay(int i);
    return 8'((i * 37 + tseed) & 255);
  endfunction

  task automatic push(logic [7:0] b, bit l);
    exp_q.push_back({l, b});
  endtask

  // Device side: a frame has just completed on the SPI stream
  task automatic end_frame();
    if (cur_q[0][7:0] == 8'hD7) begin
      if (cur_q.size() != 2 || cur_q[1] != 9'h100) poll_bad++;
      if (busy_left > 0) begin
        busy_left--;
        rx_byte = {1'b0, 7'($urandom)};
      end else begin
        rx_byte = {1'b1, (last_cmp ? (cmp_n - 1 == mm) : 1'($urandom)), 6'($urandom)};
        dev_ready = 1'b1;
      end
      rx_cnt = 1 + int'($urandom % 3);
    end else begin
      if (!dev_ready) cmd_early++;
      dev_ready = 1'b0;
      busy_left = int'($urandom % 4);
      last_cmp  = (cur_q[0][7:0] == 8'h60);
      if (last_cmp) cmp_n++;
      foreach (cur_q[i]) log_q.push_back(cur_q[i]);
    end
    cur_q.delete();
  endtask

  // SPI master and payload source model
  initial begin
    tx_ready = 1'b0; pl_valid = 1'b0; pl_data = 8'h00;
    rx_valid = 1'b0; rx_data = 8'h00;
    forever begin
      @(negedge clk);
      if (rx_cnt == 1) begin
        rx_valid = 1'b1; rx_data = rx_byte; rx_cnt = 0;
      end else begin
        rx_valid = 1'b0; rx_data = 8'($urandom);
        if (rx_cnt > 1) rx_cnt--;
      end
      tx_ready = ($urandom % 4) != 0;
      pl_valid = ($urandom % 4) != 0;
      pl_data  = pay(pidx);
      #1;
      if (pl_ready && !(cur_q.size() >= 4 && cur_q[0][7:0] == 8'h82)) pl_bad++;
      if (pl_valid && pl_ready) pidx++;
      if (tx_valid && tx_ready) begin
        cur_q.push_back({tx_last, tx_data});
        if (tx_last) end_frame();
      end
    end
  end

  // Expected command frames (polls excluded) from R1, R2, R3, R5, R6
  task automatic build_exp(int addr, int len, bit ver, int mmc);
    int p, off, rem, c, k, idx, pa, ba;
    p = addr / PB; off = addr % PB; rem = len; k = 0; idx = 0;
    exp_err = 1'b0; exp_bytes = 0;
    c = (PB - off < rem) ? PB - off : rem;
    while (rem > 0) begin
      pa = p << OW;
      ba = pa + off;
      if (c < PB) begin
        push(8'h53, 0); push(8'(pa >> 16), 0); push(8'(pa >> 8), 0); push(8'h00, 1);
      end
      push(8'h82, 0); push(8'(ba >> 16), 0); push(8'(ba >> 8), 0); push(8'(ba), 0);
      for (int j = 0; j < c; j++) push(pay(k + j), j == c - 1);
      k += c;
      if (ver) begin
        push(8'h60, 0); push(8'(pa >> 16), 0); push(8'(pa >> 8), 0); push(8'h00, 1);
        if (idx == mmc) begin
          exp_err = 1'b1;
          break;
        end
      end
      exp_bytes += c; rem -= c; p++; off = 0; idx++;
      c = (rem > PB) ? PB : rem;
    end
  endtask

  task automatic run_txn(int addr, int len, bit ver, int mmc);
    int cyc, rr_bad, diff_at;
    if (timed_out) return;
    log_q.delete(); exp_q.delete(); cur_q.delete();
    pidx = 0; tseed = int'($urandom % 256); cmp_n = 0; mm = mmc;
    poll_bad = 0; cmd_early = 0; pl_bad = 0;
    dev_ready = 1'b1; last_cmp = 1'b0; busy_left = 0;
    build_exp(addr, len, ver, mmc);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(addr); req_len = LW'(len); req_verify = ver;
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    chk(bytes_done == 0, "R7", "count cleared on accept", bytes_done, 0);
    cyc = 0; rr_bad = 0;
    while (!done && cyc < 60000) begin
      if (req_ready) rr_bad++;
      @(negedge clk); #2;
      cyc++;
    end
    if (!done) begin
      timed_out = 1'b1;
      chk(1'b0, "R10", "request never finished", cyc, 0);
      return;
    end
    chk(err == exp_err, "R5", "error flag", err, exp_err);
    chk(bytes_done == LW'(exp_bytes), "R7", "bytes committed", bytes_done, exp_bytes);
    diff_at = -1;
    if (log_q.size() != exp_q.size()) diff_at = 0;
    else foreach (exp_q[i]) if (diff_at < 0 && log_q[i] != exp_q[i]) diff_at = i;
    if (diff_at < 0)
      chk(1'b1, "R1 R2 R3 R6", "frame stream", 0, 0);
    else if (log_q.size() != exp_q.size())
      chk(1'b0, "R1 R2 R3 R6", "frame stream length", log_q.size(), exp_q.size());
    else
      chk(1'b0, "R1 R2 R3 R6", $sformatf("frame byte %0d", diff_at), log_q[diff_at], exp_q[diff_at]);
    chk(poll_bad == 0 && cmd_early == 0 && dev_ready, "R4", "poll discipline",
        poll_bad + cmd_early, 0);
    chk(pl_bad == 0, "R8", "payload taken outside data phase", pl_bad, 0);
    chk(rr_bad == 0, "R10", "req_ready while busy", rr_bad, 0);
    if (len == 0) chk(log_q.size() == 0 && !err, "R9", "zero length", log_q.size(), 0);
    @(negedge clk); #2;
    chk(!done && req_ready, "R10", "done single pulse", done, 0);
    chk(bytes_done == LW'(exp_bytes), "R7", "count retained", bytes_done, exp_bytes);
  endtask

  initial begin
    #(20 * 190000);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_verify = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(req_ready && !tx_valid && !pl_ready && !done && !err && bytes_done == 0,
        "R10", "reset state", {req_ready, tx_valid, pl_ready, done, err}, 5'b10000);
    @(negedge clk);
    rst_n = 1'b1;
    run_txn(0, PB, 1'b0, -1);                 // aligned full page, no load frame
    run_txn(PB * 3 + 100, 300, 1'b1, -1);     // crosses a page boundary
    run_txn(PB * 5 + PB - 1, 1, 1'b1, -1);    // single byte at last offset
    run_txn(1000, 0, 1'b1, -1);               // R9 zero length
    run_txn(PB * 2, 600, 1'b1, 0);            // R5 mismatch on first page
    run_txn(PB * 7 + 10, 700, 1'b1, 2);       // R5 mismatch on third page
    run_txn(PB * 9, PB * 2, 1'b1, -1);        // two full pages, verified
    for (int t = 0; t < 25; t++) begin
      int a, l, m;
      bit v;
      a = int'($urandom % 200000);
      l = int'($urandom % 700);
      v = 1'($urandom);
      m = (v && ($urandom % 3 == 0)) ? int'($urandom % 3) : -1;
      run_txn(a, l, v, m);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule